// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block is a core-local timer peripheral. It keeps a 64-bit time counter that only moves forward and a 64-bit compare value, and it raises a machine timer interrupt line once the counter has caught up with the compare value. Software reaches both through a 32-bit register bus inside a 0xC0000-byte address window. Each 64-bit quantity is split into a low word and a high word, and every access moves one whole word.

A configuration input selects the time base. In cycle mode the counter advances once every 16 core clock cycles. In tick mode it advances on each cycle where an external timebase pulse is high; that pulse nominally arrives at 10 MHz.

The interrupt is sticky. Once set, it stays asserted until software writes either half of the compare value. Such a write clears the interrupt at the next clock edge, whatever value is written. The time comparison is then made again on every following cycle.

Top module: `mtimer`

## Requirements
- R1: During reset and on the first cycle after it, the time counter is zero, the compare value is all ones, `timer_irq` is low and `bus_rvalid` is low. A read of either compare word right after reset returns 0xFFFFFFFF.
- R2: With `tick_mode` low, the time counter advances by one on every 16th rising clock edge after reset is released, the first time on the 16th edge. A time read issued at edge 16 returns 0 and a time read issued at edge 17 returns 1.
- R3: With `tick_mode` high, the time counter advances by exactly one at each edge where `ext_tick` is high, and at no other edge.
- R4: A read (`bus_valid` high, `bus_write` low) returns the word at the next edge, with `bus_rvalid` high for one cycle. Address 0xBFF8 gives the low time word and 0xBFFC gives the high time word, both as the value held before that edge. Address 0x4000 gives the low compare word and 0x4004 gives the high compare word. When no read is made, `bus_rvalid` is low and `bus_rdata` is zero.
- R5: A write to 0x4000 replaces only bits 31:0 of the compare value, and a write to 0x4004 replaces only bits 63:32. The other half keeps its value.
- R6: When the time counter, taken as an unsigned number, is greater than or equal to the compare value, `timer_irq` is high from the following edge on, unless a compare write is made in that same cycle. A compare value with bit 63 set and a small time value do not raise the interrupt.
- R7: Once high, `timer_irq` stays high until a write to 0x4000 or 0x4004 is made. That write forces `timer_irq` low at the next edge, even if the new compare value has already been reached. The comparison is made again one cycle later.
- R8: Writes to any address other than 0x4000 and 0x4004 are ignored. This includes the time words, which are read-only, and any address with bits 1:0 non-zero. Reads at any address other than the four listed in R4 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_mode | input | 1 | 0: advance every 16 core cycles; 1: advance on `ext_tick` |
| ext_tick | input | 1 | Timebase pulse, one cycle wide, used in tick mode |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 20 | Byte offset within the timer window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_rdata | output | 32 | Read data, zero when no read returns |
| timer_irq | output | 1 | Machine timer interrupt pending |

## Verification
A wrong prescaler phase or a lost tick shows up in the next read of a time word, since every time read is compared with the bench's own count. The error appears at the latest 16 cycles after it occurs, once the counter should have moved. A compare half that has been corrupted or written to the wrong place shows up at the next compare read-back, and also as an interrupt edge that comes one or more cycles off, because `timer_irq` is compared on every clock. A missed clear on a compare write shows up as `timer_irq` still high on the very next cycle.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    localparam int MT_BUS_W  = 32;
    localparam int MT_TIME_W = 64;
    localparam int MT_ADDR_W = 20;
    localparam int MT_DIV    = 16;
    localparam int MT_WORDS  = MT_TIME_W / MT_BUS_W;

    localparam logic [MT_ADDR_W-1:0] OFS_CMP_LO  = 20'h04000;
    localparam logic [MT_ADDR_W-1:0] OFS_CMP_HI  = 20'h04004;
    localparam logic [MT_ADDR_W-1:0] OFS_TIME_LO = 20'h0BFF8;
    localparam logic [MT_ADDR_W-1:0] OFS_TIME_HI = 20'h0BFFC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_TIME_LO,
        SEL_TIME_HI
    } mt_sel_e;

    typedef struct packed {
        logic                 valid;
        logic                 write;
        logic [MT_ADDR_W-1:0] addr;
        logic [MT_BUS_W-1:0]  wdata;
    } mt_req_t;

    function automatic mt_sel_e mt_decode(input logic [MT_ADDR_W-1:0] a);
        mt_sel_e s;
        case (a)
            OFS_CMP_LO:  s = SEL_CMP_LO;
            OFS_CMP_HI:  s = SEL_CMP_HI;
            OFS_TIME_LO: s = SEL_TIME_LO;
            OFS_TIME_HI: s = SEL_TIME_HI;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mtimer_prescale.sv
module mtimer_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic use_ext,
    input  logic ext_tick,
    output logic adv
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic cyc_adv;

    generate
        if (DIV <= 1) begin : g_nodiv
            assign cyc_adv = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign cyc_adv = (cnt == CW'(DIV - 1));
        end
    endgenerate

    assign adv = use_ext ? ext_tick : cyc_adv;
endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (adv) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp #(
    parameter int W     = 64,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W/BUS_W-1:0] wr_word,
    input  logic [BUS_W-1:0] wdata,
    input  logic [W-1:0]     time_val,
    output logic [W-1:0]     value,
    output logic             irq
);
    localparam int NW = W / BUS_W;

    genvar g;
    generate
        for (g = 0; g < NW; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    value[g*BUS_W +: BUS_W] <= '1;
                end else if (wr_word[g]) begin
                    value[g*BUS_W +: BUS_W] <= wdata;
                end
            end
        end
    endgenerate

    logic reached;
    assign reached = (time_val >= value);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (|wr_word) begin
            irq <= 1'b0;
        end else if (reached) begin
            irq <= 1'b1;
        end
    end
endmodule

// File: rtl/mtimer.sv
module mtimer
    import mtimer_pkg::*;
#(
    parameter int DIV = MT_DIV
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_mode,
    input  logic                 ext_tick,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [MT_ADDR_W-1:0] bus_addr,
    input  logic [MT_BUS_W-1:0]  bus_wdata,
    output logic                 bus_rvalid,
    output logic [MT_BUS_W-1:0]  bus_rdata,
    output logic                 timer_irq
);
    mt_req_t                req;
    mt_sel_e                sel;
    logic                   adv;
    logic [MT_TIME_W-1:0]   time_val;
    logic [MT_TIME_W-1:0]   cmp_val;
    logic [MT_WORDS-1:0]    wr_word;
    logic [MT_BUS_W-1:0]    rd_mux;
    logic                   rd_req;

    assign req = '{valid: bus_valid, write: bus_write, addr: bus_addr, wdata: bus_wdata};
    assign sel = mt_decode(req.addr);

    assign wr_word[0] = req.valid && req.write && (sel == SEL_CMP_LO);
    assign wr_word[1] = req.valid && req.write && (sel == SEL_CMP_HI);
    assign rd_req     = req.valid && !req.write;

    mtimer_prescale #(.DIV(DIV)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .use_ext  (tick_mode),
        .ext_tick (ext_tick),
        .adv      (adv)
    );

    mtimer_counter #(.W(MT_TIME_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .value (time_val)
    );

    mtimer_cmp #(.W(MT_TIME_W), .BUS_W(MT_BUS_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .wr_word  (wr_word),
        .wdata    (req.wdata),
        .time_val (time_val),
        .value    (cmp_val),
        .irq      (timer_irq)
    );

    always_comb begin
        case (sel)
            SEL_CMP_LO:  rd_mux = cmp_val[MT_BUS_W-1:0];
            SEL_CMP_HI:  rd_mux = cmp_val[MT_TIME_W-1:MT_BUS_W];
            SEL_TIME_LO: rd_mux = time_val[MT_BUS_W-1:0];
            SEL_TIME_HI: rd_mux = time_val[MT_TIME_W-1:MT_BUS_W];
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_req;
            bus_rdata  <= rd_req ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/mtimer_checker.sv
module mtimer_checker
    import mtimer_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [MT_ADDR_W-1:0] bus_addr,
    input logic                 bus_rvalid,
    input logic [MT_BUS_W-1:0]  bus_rdata,
    input logic                 timer_irq,
    input logic [MT_TIME_W-1:0] time_val,
    input logic [MT_TIME_W-1:0] cmp_val
);
    logic wr_lo, wr_hi, cmp_wr, rd_other;
    assign wr_lo    = bus_valid && bus_write && (bus_addr == 20'h04000);
    assign wr_hi    = bus_valid && bus_write && (bus_addr == 20'h04004);
    assign cmp_wr   = wr_lo || wr_hi;
    assign rd_other = bus_valid && !bus_write && (bus_addr != 20'h04000) &&
                      (bus_addr != 20'h04004) && (bus_addr != 20'h0BFF8) &&
                      (bus_addr != 20'h0BFFC);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (time_val == '0 && cmp_val == '1 && !timer_irq && !bus_rvalid));

    a_r2_time_step: assert property (@(posedge clk) disable iff (rst)
        (time_val == $past(time_val)) || (time_val == $past(time_val) + 64'd1));

    a_r4_read_valid: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rvalid);

    a_r4_no_read_idle: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> (!bus_rvalid && bus_rdata == '0));

    a_r5_hi_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> (cmp_val[63:32] == $past(cmp_val[63:32])));

    a_r5_lo_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo) |=> (cmp_val[31:0] == $past(cmp_val[31:0])));

    a_r6_fire: assert property (@(posedge clk) disable iff (rst)
        (time_val >= cmp_val && !cmp_wr) |=> timer_irq);

    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> !timer_irq);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (timer_irq && !cmp_wr) |=> timer_irq);

    a_r8_other_zero: assert property (@(posedge clk) disable iff (rst)
        rd_other |=> (bus_rdata == '0));

    a_r8_cmp_stable: assert property (@(posedge clk) disable iff (rst)
        !cmp_wr |=> $stable(cmp_val));
endmodule

bind mtimer mtimer_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .timer_irq  (timer_irq),
    .time_val   (time_val),
    .cmp_val    (cmp_val)
);

// File: tb/mtimer_bench.sv
module mtimer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_mode = 1'b0;
    logic        ext_tick = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        timer_irq;

    always #4 clk = ~clk;

    mtimer u_mtimer (
        .clk        (clk),
        .rst        (rst),
        .tick_mode  (tick_mode),
        .ext_tick   (ext_tick),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .timer_irq  (timer_irq)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // behavioural reference state
    longint unsigned m_time, m_cmp;
    int              m_pre;
    bit              m_irq, m_rv;
    logic [31:0]     m_rd;

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        n_checks++;
        if (timer_irq !== m_irq || bus_rvalid !== m_rv || bus_rdata !== m_rd) begin
            n_fails++;
            $display("FAIL %s model: actual irq=%0b rv=%0b rd=0x%0h expected irq=%0b rv=%0b rd=0x%0h",
                     cur_req, timer_irq, bus_rvalid, bus_rdata, m_irq, m_rv, m_rd);
        end
    endtask

    task automatic step(input bit v, input bit w, input logic [19:0] a,
                        input logic [31:0] d, input bit t);
        bit adv, n_irq, is_cmp_wr;
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; ext_tick = t;
        adv = tick_mode ? t : (m_pre == 15);
        m_rv = v && !w;
        m_rd = 32'h0;
        if (m_rv) begin
            if (a == 20'h0BFF8)      m_rd = m_time[31:0];
            else if (a == 20'h0BFFC) m_rd = m_time[63:32];
            else if (a == 20'h04000) m_rd = m_cmp[31:0];
            else if (a == 20'h04004) m_rd = m_cmp[63:32];
        end
        is_cmp_wr = v && w && (a == 20'h04000 || a == 20'h04004);
        n_irq = is_cmp_wr ? 1'b0 : (m_irq || (m_time >= m_cmp));
        m_irq = n_irq;
        if (v && w && a == 20'h04000) m_cmp[31:0]  = d;
        if (v && w && a == 20'h04004) m_cmp[63:32] = d;
        m_pre = (m_pre + 1) % 16;
        if (adv) m_time = m_time + 1;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; ext_tick = 1'b0;
        cmp_model();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 20'h0, 32'h0, 0);
    endtask

    task automatic rd(input logic [19:0] a, output logic [31:0] v);
        step(1, 0, a, 32'h0, 0);
        v = bus_rdata;
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, a0, b0, t0, x0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_time = 0; m_cmp = 64'hFFFF_FFFF_FFFF_FFFF; m_pre = 0;
        m_irq = 0; m_rv = 0; m_rd = 0;

        // R1 reset state
        cur_req = "R1";
        chk("R1 irq", timer_irq, 0);
        chk("R1 rvalid", bus_rvalid, 0);
        rd(20'h04000, v); chk("R1 cmp lo", v, 32'hFFFF_FFFF);   // edge 1
        rd(20'h04004, v); chk("R1 cmp hi", v, 32'hFFFF_FFFF);   // edge 2
        rd(20'h0BFF8, v); chk("R1 time lo", v, 0);              // edge 3

        // R2 cycle-mode prescale
        cur_req = "R2";
        idle(12);                                               // edges 4..15
        rd(20'h0BFF8, v); chk("R2 edge16", v, 0);
        rd(20'h0BFF8, v); chk("R2 edge17", v, 1);
        idle(40);
        rd(20'h0BFFC, v); chk("R2 hi", v, 0);

        // R3 tick mode
        cur_req = "R3";
        tick_mode = 1'b1;
        rd(20'h0BFF8, a0);
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 20'h0, 32'h0, 1);
            idle(i);
        end
        idle(20);
        rd(20'h0BFF8, b0);
        chk("R3 five ticks", b0 - a0, 5);

        // R4/R5 compare access
        cur_req = "R5";
        rd(20'h0BFF8, t0);
        wr(20'h04004, 32'h0);
        wr(20'h04000, t0 + 6);
        rd(20'h04004, v); chk("R5 hi kept after lo write", v, 0);
        rd(20'h04000, v); chk("R4 cmp lo readback", v, t0 + 6);
        chk("R5 rvalid", bus_rvalid, 1);
        idle(1);
        chk("R4 rvalid idle", bus_rvalid, 0);

        // R6 interrupt timing
        cur_req = "R6";
        for (int i = 0; i < 6; i++) step(0, 0, 20'h0, 32'h0, 1);
        chk("R6 not yet", timer_irq, 0);
        idle(1);
        chk("R6 fired", timer_irq, 1);

        // R7 sticky and clear
        cur_req = "R7";
        idle(3);
        chk("R7 sticky", timer_irq, 1);
        wr(20'h04000, t0 + 100);
        chk("R7 cleared", timer_irq, 0);
        idle(2);
        chk("R7 stays low", timer_irq, 0);
        wr(20'h04000, 32'h0);
        chk("R7 clear on reached value", timer_irq, 0);
        idle(1);
        chk("R7 re-evaluated", timer_irq, 1);

        // R8 ignored accesses
        cur_req = "R8";
        rd(20'h0BFF8, x0);
        wr(20'h0BFF8, 32'h1234_5678);
        wr(20'h0BFFC, 32'h0000_FFFF);
        rd(20'h0BFF8, v); chk("R8 time lo read-only", v, x0);
        rd(20'h0BFFC, v); chk("R8 time hi read-only", v, 0);
        wr(20'h04002, 32'hAAAA_AAAA);
        rd(20'h04000, v); chk("R8 unaligned write ignored", v, 0);
        chk("R8 irq kept", timer_irq, 1);
        rd(20'h04001, v); chk("R8 unaligned read", v, 0);
        rd(20'h08000, v); chk("R8 other read", v, 0);
        rd(20'hFFFFC, v); chk("R8 out of window read", v, 0);

        // R6 unsigned compare
        cur_req = "R6";
        wr(20'h04004, 32'h8000_0000);
        idle(3);
        chk("R6 unsigned no fire", timer_irq, 0);

        // back to cycle mode, model runs alongside
        cur_req = "R2";
        tick_mode = 1'b0;
        for (int i = 0; i < 10; i++) begin
            idle(7);
            rd(20'h0BFF8, v);
        end
        cur_req = "R4";
        rd(20'h0BFFC, v);
        rd(20'h04004, v); chk("R4 cmp hi readback", v, 32'h8000_0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule